// File: doc/BRIEF.md
# Relative-Addressed Shader Operand Fetch

This unit sits between the instruction decoder and the register banks of a vector shader core. For each decoded instruction it turns up to three source operand specifiers into read indices for three banks: input, temporary and float-uniform. It then picks the right four-lane word for each source. Reads from the uniform bank may be shifted by the value of one of three address registers. The shift is discarded when the register holds a value outside signed 8-bit range, and the shifted index wraps within 7 bits. Any effective uniform slot past the end of the bank returns a constant vector of ones and raises a per-source flag. A destination specifier is decoded into a write enable for the output bank, a write enable for the temporary bank, or no write.

The register banks are external. The unit drives their read indices combinationally and expects their data back in the same cycle. It registers the three resolved operands, the out-of-range flags and the destination decode together, one cycle after a valid instruction. The address registers live inside the unit and are loaded through a synchronous write port.

Top module: `shader_operand_fetch`

## Requirements
- R1: A source specifier (8 bits) selects its bank by value. 0x00–0x0F read the input bank at index spec[3:0]. 0x10–0x1F read the temporary bank at index spec[3:0]. 0x20–0x7F read the uniform bank at raw index spec−0x20. 0x80–0xFF produce four lanes of zero (0x000000).
- R2: The 2-bit address selector `arSel` value 0 applies no offset. Values 1, 2 and 3 take the offset from address register 0, 1 and 2.
- R3: The offset only changes uniform-bank reads. Input and temporary sources always use the raw index, even in the slot that takes the offset.
- R4: An address register value below −128 or above +127 contributes an offset of zero.
- R5: The effective uniform index is (raw index + offset) modulo 128.
- R6: When the effective uniform index is 96 or more, all four lanes of that source are 0x3F0000 and its `opOob` bit is 1. Otherwise `opOob` is 0 for that source.
- R7: With `isMad`=0, the offset applies to source 1 when `inverted`=0 and to source 2 when `inverted`=1. Source 3 is resolved without offset.
- R8: With `isMad`=1, source 1 never takes the offset. Source 2 takes it when `inverted`=0 and source 3 takes it when `inverted`=1.
- R9: A destination specifier below 0x10 asserts `dstOutWe`. 0x10–0x1F asserts `dstTmpWe`. Values above 0x1F assert neither. `dstIdx` carries spec[3:0].
- R10: Results appear on the cycle after `inValid`=1, with `outValid`=1. After a cycle with `inValid`=0, `outValid` and both write enables are 0 and the operand outputs keep their previous values.
- R11: `arWrEn` with `arWrSel` 0–2 loads that 32-bit address register at the clock edge, and `arWrSel`=3 loads nothing. A fetch presented in the same cycle as a write uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| arWrEn | input | 1 | Address register write strobe |
| arWrSel | input | 2 | Address register to write (0–2) |
| arWrData | input | AR_W | Value to write, signed |
| inValid | input | 1 | Decoded instruction present |
| isMad | input | 1 | Three-source multiply-add form |
| inverted | input | 1 | Inverted operand form |
| arSel | input | 2 | Address register selector, 0 = none |
| srcSpec | input | 3×8 | Source specifiers, index 0 = source 1 |
| dstSpec | input | 8 | Destination specifier |
| inRdIdx | output | 3×4 | Input bank read index per source |
| inRdData | input | 3×4·LANE_W | Input bank read data per source |
| tmpRdIdx | output | 3×4 | Temporary bank read index per source |
| tmpRdData | input | 3×4·LANE_W | Temporary bank read data per source |
| uniRdIdx | output | 3×7 | Uniform bank read index per source |
| uniRdData | input | 3×4·LANE_W | Uniform bank read data per source |
| outValid | output | 1 | Registered results valid |
| opOut | output | 3×4·LANE_W | Resolved operands, lane 0 in the low bits |
| opOob | output | 3 | Per-source out-of-range uniform flag |
| dstOutWe | output | 1 | Write to output bank |
| dstTmpWe | output | 1 | Write to temporary bank |
| dstIdx | output | 4 | Destination bank index |

## Verification
Read indices are combinational, so the bench's bank model answers them in the same cycle it presents an instruction. Every registered result (operands, flags, destination decode, `outValid`) is due exactly one clock edge after `inValid`. The bench drives each instruction on a falling edge and compares all outputs at the next falling edge, so exactly one rising edge lies in between. An address register write changes the register at the edge that also captures a fetch in the same cycle, so the expected value for that fetch comes from the bench's model before the write is applied.

// File: rtl/opf_pkg.sv
package opf_pkg;
  localparam int NUM_SRC    = 3;
  localparam int NUM_AR     = 3;
  localparam int LANES      = 4;
  localparam int SPEC_W     = 8;
  localparam int BANK_IDX_W = 4;
  localparam int UNI_IDX_W  = 7;

  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_IN   = 3'd1,
    SRC_TMP  = 3'd2,
    SRC_UNI  = 3'd3,
    SRC_ONE  = 3'd4
  } srcKind_e;

  typedef struct packed {
    logic                       capture;
    srcKind_e [NUM_SRC-1:0]     kind;
    logic                       dstOutWe;
    logic                       dstTmpWe;
  } fetchStrobe_t;
endpackage

// File: rtl/opf_ctrl.sv
module opf_ctrl
  import opf_pkg::*;
#(
  parameter int AR_W      = 32,
  parameter int UNI_SLOTS = 96
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 inValid,
  input  logic                                 isMad,
  input  logic                                 inverted,
  input  logic [1:0]                           arSel,
  input  logic [NUM_SRC-1:0][SPEC_W-1:0]       srcSpec,
  input  logic [SPEC_W-1:0]                    dstSpec,
  input  logic [NUM_AR-1:0][AR_W-1:0]          arVal,
  output logic [NUM_SRC-1:0][BANK_IDX_W-1:0]   inRdIdx,
  output logic [NUM_SRC-1:0][BANK_IDX_W-1:0]   tmpRdIdx,
  output logic [NUM_SRC-1:0][UNI_IDX_W-1:0]    uniRdIdx,
  output fetchStrobe_t                         strobe
);
  localparam logic [UNI_IDX_W-1:0] UNI_BASE = UNI_IDX_W'(7'h20);

  logic [1:0]      offSlot;
  logic [AR_W-1:0] arPick;
  logic            arFits;
  logic [7:0]      offByte;

  // Which source slot receives the relative offset
  always_comb begin
    if (isMad) offSlot = inverted ? 2'd2 : 2'd1;
    else       offSlot = inverted ? 2'd1 : 2'd0;
  end

  // Address register selection and signed 8-bit range test
  always_comb begin
    arPick = '0;
    for (int a = 0; a < NUM_AR; a++) begin
      if (arSel == 2'(a + 1)) arPick = arVal[a];
    end
    arFits  = (&arPick[AR_W-1:7]) || !(|arPick[AR_W-1:7]);
    offByte = ((arSel != 2'd0) && arFits) ? arPick[7:0] : 8'h00;
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    logic [SPEC_W-1:0]    spec;
    logic [UNI_IDX_W-1:0] rawIdx;
    logic [UNI_IDX_W-1:0] effIdx;
    logic                 takeOff;
    srcKind_e             kind;

    assign spec    = srcSpec[s];
    assign takeOff = (offSlot == 2'(s));
    assign rawIdx  = spec[UNI_IDX_W-1:0] - UNI_BASE;
    assign effIdx  = rawIdx + (takeOff ? offByte[UNI_IDX_W-1:0] : '0);

    assign inRdIdx[s]  = spec[BANK_IDX_W-1:0];
    assign tmpRdIdx[s] = spec[BANK_IDX_W-1:0];
    assign uniRdIdx[s] = effIdx;

    always_comb begin
      if (spec[7])
        kind = SRC_ZERO;
      else if (spec[6:5] != 2'b00)
        kind = (32'(effIdx) >= UNI_SLOTS) ? SRC_ONE : SRC_UNI;
      else if (spec[4])
        kind = SRC_TMP;
      else
        kind = SRC_IN;
    end

    assign strobe.kind[s] = kind;
  end

  assign strobe.capture  = inValid;
  assign strobe.dstOutWe = (dstSpec < SPEC_W'(8'h10));
  assign strobe.dstTmpWe = (dstSpec >= SPEC_W'(8'h10)) && (dstSpec < SPEC_W'(8'h20));

  // A uniform source 1 with no selector reads its raw slot
  AST_NOSEL_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && arSel == 2'd0 && !srcSpec[0][7] && srcSpec[0][6:5] != 2'b00)
      |-> (uniRdIdx[0] == srcSpec[0][6:0] - 7'h20)); // R2

  // Multiply-add never shifts source 1
  AST_MAD_SRC1_RAW: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isMad && !srcSpec[0][7] && srcSpec[0][6:5] != 2'b00)
      |-> (uniRdIdx[0] == srcSpec[0][6:0] - 7'h20)); // R8

  // Input and temporary reads follow the specifier regardless of offset
  AST_BANK_RAW: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> (inRdIdx[1] == srcSpec[1][3:0] && tmpRdIdx[2] == srcSpec[2][3:0])); // R3
endmodule

// File: rtl/opf_datapath.sv
module opf_datapath
  import opf_pkg::*;
#(
  parameter int                LANE_W   = 24,
  parameter int                AR_W     = 32,
  parameter logic [LANE_W-1:0] ONE_CODE = 24'h3F0000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  arWrEn,
  input  logic [1:0]                            arWrSel,
  input  logic [AR_W-1:0]                       arWrData,
  output logic [NUM_AR-1:0][AR_W-1:0]           arVal,
  input  fetchStrobe_t                          strobe,
  input  logic [BANK_IDX_W-1:0]                 dstBankIdx,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  inRdData,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  tmpRdData,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  uniRdData,
  output logic                                  outValid,
  output logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  opOut,
  output logic [NUM_SRC-1:0]                    opOob,
  output logic                                  dstOutWe,
  output logic                                  dstTmpWe,
  output logic [BANK_IDX_W-1:0]                 dstIdx
);
  localparam int VEC_W = LANES * LANE_W;
  localparam logic [VEC_W-1:0] ONES_VEC = {LANES{ONE_CODE}};

  logic [NUM_AR-1:0][AR_W-1:0] arFile;

  // Address register file with one synchronous write port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      arFile <= '0;
    end else if (arWrEn) begin
      for (int a = 0; a < NUM_AR; a++) begin
        if (arWrSel == 2'(a)) arFile[a] <= arWrData;
      end
    end
  end
  assign arVal = arFile;

  for (genvar s = 0; s < NUM_SRC; s++) begin : gLane
    logic [VEC_W-1:0] nextOp;

    always_comb begin
      unique case (strobe.kind[s])
        SRC_IN:  nextOp = inRdData[s];
        SRC_TMP: nextOp = tmpRdData[s];
        SRC_UNI: nextOp = uniRdData[s];
        SRC_ONE: nextOp = ONES_VEC;
        default: nextOp = '0;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opOut[s] <= '0;
        opOob[s] <= 1'b0;
      end else if (strobe.capture) begin
        opOut[s] <= nextOp;
        opOob[s] <= (strobe.kind[s] == SRC_ONE);
      end
    end

    // Flagged sources carry the constant vector of ones
    AST_OOB_ONES: assert property (@(posedge clk) disable iff (!rstN)
      (outValid && opOob[s]) |-> (opOut[s] == ONES_VEC)); // R6
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      dstOutWe <= 1'b0;
      dstTmpWe <= 1'b0;
      dstIdx   <= '0;
    end else begin
      outValid <= strobe.capture;
      dstOutWe <= strobe.capture && strobe.dstOutWe;
      dstTmpWe <= strobe.capture && strobe.dstTmpWe;
      if (strobe.capture) dstIdx <= dstBankIdx;
    end
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> outValid); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!dstOutWe && !dstTmpWe)); // R10

  AST_DST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    !(dstOutWe && dstTmpWe)); // R9

  AST_AR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (arWrEn && arWrSel != 2'd3) |=> (arFile[$past(arWrSel)] == $past(arWrData))); // R11
endmodule

// File: rtl/shader_operand_fetch.sv
module shader_operand_fetch
  import opf_pkg::*;
#(
  parameter int                LANE_W    = 24,
  parameter int                AR_W      = 32,
  parameter int                UNI_SLOTS = 96,
  parameter logic [LANE_W-1:0] ONE_CODE  = 24'h3F0000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  arWrEn,
  input  logic [1:0]                            arWrSel,
  input  logic [AR_W-1:0]                       arWrData,
  input  logic                                  inValid,
  input  logic                                  isMad,
  input  logic                                  inverted,
  input  logic [1:0]                            arSel,
  input  logic [NUM_SRC-1:0][SPEC_W-1:0]        srcSpec,
  input  logic [SPEC_W-1:0]                     dstSpec,
  output logic [NUM_SRC-1:0][BANK_IDX_W-1:0]    inRdIdx,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  inRdData,
  output logic [NUM_SRC-1:0][BANK_IDX_W-1:0]    tmpRdIdx,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  tmpRdData,
  output logic [NUM_SRC-1:0][UNI_IDX_W-1:0]     uniRdIdx,
  input  logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  uniRdData,
  output logic                                  outValid,
  output logic [NUM_SRC-1:0][LANES*LANE_W-1:0]  opOut,
  output logic [NUM_SRC-1:0]                    opOob,
  output logic                                  dstOutWe,
  output logic                                  dstTmpWe,
  output logic [BANK_IDX_W-1:0]                 dstIdx
);
  fetchStrobe_t                 strobe;
  logic [NUM_AR-1:0][AR_W-1:0]  arVal;

  opf_ctrl #(.AR_W(AR_W), .UNI_SLOTS(UNI_SLOTS)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isMad(isMad),
    .inverted(inverted), .arSel(arSel), .srcSpec(srcSpec),
    .dstSpec(dstSpec), .arVal(arVal), .inRdIdx(inRdIdx),
    .tmpRdIdx(tmpRdIdx), .uniRdIdx(uniRdIdx), .strobe(strobe)
  );

  opf_datapath #(.LANE_W(LANE_W), .AR_W(AR_W), .ONE_CODE(ONE_CODE)) uData (
    .clk(clk), .rstN(rstN), .arWrEn(arWrEn), .arWrSel(arWrSel),
    .arWrData(arWrData), .arVal(arVal), .strobe(strobe),
    .dstBankIdx(dstSpec[BANK_IDX_W-1:0]), .inRdData(inRdData),
    .tmpRdData(tmpRdData), .uniRdData(uniRdData), .outValid(outValid),
    .opOut(opOut), .opOob(opOob), .dstOutWe(dstOutWe),
    .dstTmpWe(dstTmpWe), .dstIdx(dstIdx)
  );
endmodule

// File: tb/tb_shader_operand_fetch.sv
module tb_shader_operand_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int VEC = 96;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic arWrEn = 1'b0;
  logic [1:0] arWrSel = '0;
  logic [31:0] arWrData = '0;
  logic inValid = 1'b0, isMad = 1'b0, inverted = 1'b0;
  logic [1:0] arSel = '0;
  logic [2:0][7:0] srcSpec = '0;
  logic [7:0] dstSpec = '0;
  logic [2:0][3:0] inRdIdx, tmpRdIdx;
  logic [2:0][6:0] uniRdIdx;
  logic [2:0][VEC-1:0] inRdData, tmpRdData, uniRdData;
  logic outValid;
  logic [2:0][VEC-1:0] opOut;
  logic [2:0] opOob;
  logic dstOutWe, dstTmpWe;
  logic [3:0] dstIdx;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  logic signed [31:0] arModel [3];

  always #(CLK_PERIOD/2) clk = ~clk;

  shader_operand_fetch dut (
    .clk(clk), .rstN(rstN), .arWrEn(arWrEn), .arWrSel(arWrSel),
    .arWrData(arWrData), .inValid(inValid), .isMad(isMad),
    .inverted(inverted), .arSel(arSel), .srcSpec(srcSpec),
    .dstSpec(dstSpec), .inRdIdx(inRdIdx), .inRdData(inRdData),
    .tmpRdIdx(tmpRdIdx), .tmpRdData(tmpRdData), .uniRdIdx(uniRdIdx),
    .uniRdData(uniRdData), .outValid(outValid), .opOut(opOut),
    .opOob(opOob), .dstOutWe(dstOutWe), .dstTmpWe(dstTmpWe),
    .dstIdx(dstIdx)
  );

  // Distinct word per bank, index and lane
  function automatic logic [VEC-1:0] pat(int bank, int idx);
    logic [VEC-1:0] v;
    for (int l = 0; l < 4; l++) v[l*24 +: 24] = {4'(bank), 8'(idx), 4'(l), 8'h5A};
    return v;
  endfunction

  always_comb begin
    for (int s = 0; s < 3; s++) begin
      inRdData[s]  = pat(1, int'(inRdIdx[s]));
      tmpRdData[s] = pat(2, int'(tmpRdIdx[s]));
      uniRdData[s] = pat(3, int'(uniRdIdx[s]));
    end
  end

  task automatic check(string req, logic [VEC-1:0] act, logic [VEC-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected operand from the requirements
  function automatic logic [VEC:0] expOp(logic [7:0] spec, bit takeOff, int sel);
    int off = 0;
    int eff;
    if (spec >= 8'h80) return '0;                                     // R1 zero
    if (spec < 8'h10) return {1'b0, pat(1, int'(spec[3:0]))};         // R1 input
    if (spec < 8'h20) return {1'b0, pat(2, int'(spec[3:0]))};         // R1 temp
    if (takeOff && sel != 0) begin                                    // R2
      off = int'(arModel[sel-1]);
      if (off < -128 || off > 127) off = 0;                           // R4
    end
    eff = (int'(spec) - 32 + off) & 127;                              // R5
    if (eff >= 96) return {1'b1, {4{24'h3F0000}}};                    // R6
    return {1'b0, pat(3, eff)};
  endfunction

  task automatic writeAr(logic [1:0] sel, logic [31:0] val);
    arWrEn = 1'b1; arWrSel = sel; arWrData = val;
    @(negedge clk);
    arWrEn = 1'b0;
    if (sel != 2'd3) arModel[sel] = signed'(val);
  endtask

  // Drive at a falling edge, check at the next falling edge
  task automatic fetch(string req, bit mad, bit inv, logic [1:0] sel,
                       logic [7:0] s1, logic [7:0] s2, logic [7:0] s3,
                       logic [7:0] dst, bit arWrite = 0,
                       logic [1:0] wSel = 0, logic [31:0] wVal = 0);
    int slot;
    logic [VEC:0] e [3];
    logic [2:0] eOob;
    logic [7:0] sp [3];
    sp[0] = s1; sp[1] = s2; sp[2] = s3;
    slot = mad ? (inv ? 2 : 1) : (inv ? 1 : 0);                       // R7 R8
    for (int s = 0; s < 3; s++) begin
      e[s] = expOp(sp[s], s == slot, int'(sel));
      eOob[s] = e[s][VEC];
    end
    inValid = 1'b1; isMad = mad; inverted = inv; arSel = sel;
    srcSpec[0] = s1; srcSpec[1] = s2; srcSpec[2] = s3; dstSpec = dst;
    if (arWrite) begin
      arWrEn = 1'b1; arWrSel = wSel; arWrData = wVal;
    end
    @(negedge clk);
    inValid = 1'b0;
    arWrEn = 1'b0;
    if (arWrite && wSel != 2'd3) arModel[wSel] = signed'(wVal);
    for (int s = 0; s < 3; s++) check(req, opOut[s], e[s][VEC-1:0]);
    check({req, " R6 flag"}, VEC'(opOob), VEC'(eOob));
    check({req, " R10 valid"}, VEC'(outValid), VEC'(1));
    check({req, " R9 dest"}, VEC'({dstOutWe, dstTmpWe, dstIdx}),
          VEC'({dst < 8'h10, dst >= 8'h10 && dst < 8'h20, dst[3:0]}));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [VEC-1:0] held;
    void'($urandom(32'd2024));
    for (int a = 0; a < 3; a++) arModel[a] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // Reset state
    check("R10 reset valid", VEC'(outValid), '0);
    check("R10 reset op", opOut[0], '0);
    check("R10 reset we", VEC'({dstOutWe, dstTmpWe}), '0);

    // Bank decode and destination decode, no offset
    fetch("R1 banks", 0, 0, 2'd0, 8'h05, 8'h1A, 8'h20, 8'h0F);
    fetch("R1 top uniform/zero", 1, 0, 2'd0, 8'h7F, 8'h80, 8'hFF, 8'h10);
    fetch("R9 tmp edge", 0, 0, 2'd0, 8'h00, 8'h10, 8'h1F, 8'h1F);
    fetch("R9 discard", 0, 0, 2'd0, 8'h30, 8'h40, 8'h50, 8'h20);

    // Address register boundaries
    writeAr(2'd0, 32'd127);
    writeAr(2'd1, 32'd128);
    writeAr(2'd2, 32'hFFFFFF80);
    fetch("R4 plus127", 0, 0, 2'd1, 8'h20, 8'h21, 8'h22, 8'h00);
    fetch("R4 plus128 dropped", 0, 0, 2'd2, 8'h25, 8'h21, 8'h22, 8'h00);
    fetch("R5 minus128 wraps", 0, 0, 2'd3, 8'h20, 8'h21, 8'h22, 8'h00);
    writeAr(2'd2, 32'hFFFFFF7F);
    fetch("R4 minus129 dropped", 0, 0, 2'd3, 8'h27, 8'h21, 8'h22, 8'h00);
    writeAr(2'd0, 32'hFFFFFFFF);
    fetch("R5 wrap to 127", 0, 0, 2'd1, 8'h20, 8'h20, 8'h20, 8'h00);
    writeAr(2'd0, 32'd6);
    fetch("R6 slot 96", 0, 0, 2'd1, 8'h7A, 8'h7A, 8'h7A, 8'h00);
    writeAr(2'd0, 32'd5);
    fetch("R6 slot 95", 0, 0, 2'd1, 8'h7A, 8'h7A, 8'h7A, 8'h00);

    // Slot routing
    writeAr(2'd1, 32'd3);
    fetch("R7 inverted", 0, 1, 2'd2, 8'h30, 8'h30, 8'h30, 8'h00);
    fetch("R8 mad", 1, 0, 2'd2, 8'h30, 8'h30, 8'h30, 8'h00);
    fetch("R8 mad inverted", 1, 1, 2'd2, 8'h30, 8'h30, 8'h30, 8'h00);
    fetch("R3 input in offset slot", 0, 0, 2'd2, 8'h03, 8'h13, 8'h33, 8'h00);
    fetch("R3 temp in offset slot", 1, 1, 2'd2, 8'h23, 8'h03, 8'h13, 8'h00);

    // Write in the same cycle as a fetch uses old value; select 3 writes nothing
    fetch("R11 same cycle", 0, 0, 2'd2, 8'h40, 8'h40, 8'h40, 8'h00, 1, 2'd1, 32'd9);
    fetch("R11 new value", 0, 0, 2'd2, 8'h40, 8'h40, 8'h40, 8'h00);
    writeAr(2'd3, 32'd50);
    fetch("R11 sel3 ignored", 0, 0, 2'd1, 8'h40, 8'h40, 8'h40, 8'h00);
    fetch("R11 sel3 ignored", 0, 0, 2'd3, 8'h40, 8'h40, 8'h40, 8'h00);

    // Idle cycle holds operands and blocks writes
    held = opOut[0];
    srcSpec = {8'h11, 8'h12, 8'h01}; dstSpec = 8'h01;
    @(negedge clk);
    check("R10 idle valid", VEC'(outValid), '0);
    check("R10 idle hold", opOut[0], held);
    check("R10 idle we", VEC'({dstOutWe, dstTmpWe}), '0);

    // Random mix
    for (int it = 0; it < 300; it++) begin
      if (it % 6 == 0) begin
        int pick = $urandom_range(0, 3);
        logic [31:0] v;
        case (pick)
          0: v = 32'($urandom_range(0, 255)) - 32'd128;
          1: v = $urandom;
          2: v = 32'($urandom_range(0, 40));
          default: v = ($urandom_range(0, 1) != 0) ? 32'd128 : 32'hFFFFFF7F;
        endcase
        writeAr(2'($urandom_range(0, 3)), v);
      end
      fetch("R1 R2 R5 R7 R8 random", 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)),
            8'($urandom_range(0, 255)), 8'($urandom_range(0, 63)));
    end

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule